// File: doc/BRIEF.md
# Time-Tick Master and Distributor

This block produces and spreads time-code ticks for a node or a router with several ports. A configuration input picks the mode. In master mode, a cycle counter driven by a 32-bit period creates a tick at a fixed interval. Each generated tick advances the time value and goes out on every port. In slave mode, a tick that arrives on a port is shown locally as a one-cycle pulse with its time value. If the tick is the expected successor, it is also passed on to every port except the one it came in on.

A time code is 8 bits wide. Bits [5:0] are a counter that wraps modulo 64. Bits [7:6] are control flags. The block does not encode or decode the characters on the link. It takes one valid/value pair per port and returns one request bit per port plus a shared outgoing value.

Top module: `tick_dist`

## Requirements
- R1: While rst_ni is low, and after it is released until the first tick, tick_o, time_o, tick_out_req_o and tick_out_time_o are all zero.
- R2: With master_en_i high and period_i = P > 0, a tick is generated every P clock cycles. The first tick appears P cycles after the first clock edge that samples master mode. P = 1 gives a tick on every cycle.
- R3: A master tick sets time_o bits [5:0] to the previous value plus 1 modulo 64 (63 wraps to 0) and forces bits [7:6] to 00. tick_o pulses for one cycle, in the cycle after the deciding edge.
- R4: A master tick sets every bit of tick_out_req_o for that cycle. tick_out_time_o carries the new time value.
- R5: In master mode with period_i = 0, no tick is produced and the period counter is held at zero.
- R6: In master mode, incoming ticks on any port are ignored: they change neither the outputs nor the stored time value.
- R7: In slave mode, an incoming tick produces a tick_o pulse one cycle later, with time_o equal to the full 8-bit received value, flags included.
- R8: In slave mode, a received tick whose bits [5:0] equal the stored bits [5:0] plus 1 modulo 64 is forwarded. The request bit is set on every port except the source port, and tick_out_time_o equals the received value.
- R9: In slave mode, a received tick that is not the successor still updates the stored value and pulses tick_o, but sets no request bit.
- R10: When several ports present a tick in the same cycle, only the lowest-numbered port is taken and the others are dropped.
- R11: On entering master mode, the period count restarts from zero and generated ticks continue from the stored time value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | High selects master (generate) mode; low selects slave (forward) mode |
| period_i | input | 32 | Tick interval in clock cycles; 0 stops generation |
| tick_in_valid_i | input | NUM_PORTS | Per-port strobe for a received tick |
| tick_in_time_i | input | NUM_PORTS*8 | Per-port received time code; port p uses bits [8p+7:8p] |
| tick_out_req_o | output | NUM_PORTS | Per-port request to send a tick, one cycle long |
| tick_out_time_o | output | 8 | Time code to send with the requests |
| tick_o | output | 1 | Local tick pulse |
| time_o | output | 8 | Current time code |

## Verification
The hardest situation to reach is a received tick that is the exact successor of the stored value, especially across the 63-to-0 wrap. Uniform random values almost never hit it, and when they do it is usually on a port that loses to a lower-numbered one in the same cycle. The stimulus reads the bench model's stored value and, half the time, offers its successor (with random flags) on randomly chosen ports. Directed runs add a 64-step master wrap, colliding ports, and mode changes part-way through a period.

// File: rtl/tick_dist_pkg.sv
package tick_dist_pkg;
  localparam int unsigned TIME_W = 8;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned FLAG_W = TIME_W - CNT_W;

  typedef logic [TIME_W-1:0] tcode_t;

  // next master time value: counter +1 mod 64, flags cleared
  function automatic tcode_t tc_advance(tcode_t t);
    logic [CNT_W-1:0] c;
    c = t[CNT_W-1:0] + CNT_W'(1);
    return {{FLAG_W{1'b0}}, c};
  endfunction

  function automatic logic tc_is_next(tcode_t prev, tcode_t cand);
    logic [CNT_W-1:0] c;
    c = prev[CNT_W-1:0] + CNT_W'(1);
    return cand[CNT_W-1:0] == c;
  endfunction
endpackage

// File: rtl/tick_period_gen.sv
module tick_period_gen #(
  parameter int unsigned PERIOD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                fire_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                run;

  assign run    = en_i && (period_i != '0);
  // >= so that a shortened period fires at once instead of overrunning
  assign fire_o = run && (cnt_q >= period_i - PERIOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run || fire_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + PERIOD_W'(1);
  end
endmodule

// File: rtl/tick_port_select.sv
module tick_port_select #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TIME_W    = 8
) (
  input  logic [NUM_PORTS-1:0]        valid_i,
  input  logic [NUM_PORTS*TIME_W-1:0] time_i,
  output logic                        hit_o,
  output logic [NUM_PORTS-1:0]        src_oh_o,
  output logic [TIME_W-1:0]           time_o
);
  logic [NUM_PORTS:0] lower_q;

  assign lower_q[0] = 1'b0;
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_prio
    assign src_oh_o[i]  = valid_i[i] & ~lower_q[i];
    assign lower_q[i+1] = lower_q[i] | valid_i[i];
  end
  assign hit_o = lower_q[NUM_PORTS];

  always_comb begin
    time_o = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (src_oh_o[i]) time_o = time_o | time_i[i*TIME_W +: TIME_W];
  end
endmodule

// File: rtl/tick_dist.sv
module tick_dist
  import tick_dist_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PERIOD_W  = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        master_en_i,
  input  logic [PERIOD_W-1:0]         period_i,
  input  logic [NUM_PORTS-1:0]        tick_in_valid_i,
  input  logic [NUM_PORTS*TIME_W-1:0] tick_in_time_i,
  output logic [NUM_PORTS-1:0]        tick_out_req_o,
  output logic [TIME_W-1:0]           tick_out_time_o,
  output logic                        tick_o,
  output logic [TIME_W-1:0]           time_o
);
  logic                 fire;
  logic                 hit;
  logic [NUM_PORTS-1:0] src_oh;
  tcode_t               sel_time;

  tcode_t               time_q, nxt_time;
  logic                 tick_q, nxt_tick;
  logic [NUM_PORTS-1:0] req_q, nxt_req;

  tick_period_gen #(.PERIOD_W(PERIOD_W)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (master_en_i),
    .period_i (period_i),
    .fire_o   (fire)
  );

  tick_port_select #(.NUM_PORTS(NUM_PORTS), .TIME_W(TIME_W)) u_sel (
    .valid_i  (tick_in_valid_i),
    .time_i   (tick_in_time_i),
    .hit_o    (hit),
    .src_oh_o (src_oh),
    .time_o   (sel_time)
  );

  always_comb begin
    nxt_tick = 1'b0;
    nxt_req  = '0;
    nxt_time = time_q;
    if (master_en_i) begin
      if (fire) begin
        nxt_tick = 1'b1;
        nxt_time = tc_advance(time_q);
        nxt_req  = '1;
      end
    end else if (hit) begin
      nxt_tick = 1'b1;
      nxt_time = sel_time;
      if (tc_is_next(time_q, sel_time)) nxt_req = ~src_oh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      tick_q <= 1'b0;
      req_q  <= '0;
    end else begin
      time_q <= nxt_time;
      tick_q <= nxt_tick;
      req_q  <= nxt_req;
    end
  end

  assign tick_o          = tick_q;
  assign time_o          = time_q;
  assign tick_out_time_o = time_q;
  assign tick_out_req_o  = req_q;
endmodule

// File: rtl/tick_dist_checks.sv
module tick_dist_checks #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PERIOD_W  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 master_en_i,
  input logic [PERIOD_W-1:0]  period_i,
  input logic [NUM_PORTS-1:0] tick_out_req_o,
  input logic                 tick_o,
  input logic [7:0]           time_o
);
  assert_req_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_out_req_o != '0) |-> tick_o);

  assert_master_all_ports_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(master_en_i)) |-> (tick_out_req_o == {NUM_PORTS{1'b1}}));

  assert_master_flags_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(master_en_i)) |-> (time_o[7:6] == 2'b00));

  assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && master_en_i && period_i > 1 && $stable(period_i)) |=> !tick_o);

  assert_no_tick_zero_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(master_en_i) && $past(period_i) == '0) |-> !tick_o);

  assert_skip_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_out_req_o != '0 && !$past(master_en_i)) |-> ($countones(tick_out_req_o) == NUM_PORTS - 1));
endmodule

bind tick_dist tick_dist_checks #(.NUM_PORTS(NUM_PORTS), .PERIOD_W(PERIOD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .master_en_i    (master_en_i),
  .period_i       (period_i),
  .tick_out_req_o (tick_out_req_o),
  .tick_o         (tick_o),
  .time_o         (time_o)
);

// File: tb/test_tick_dist.sv
module test_tick_dist;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         master_en = 1'b0;
  logic [31:0]  period = '0;
  logic [N-1:0] tv = '0;
  logic [N*8-1:0] tt = '0;
  logic [N-1:0] req;
  logic [7:0]   out_time, time_v;
  logic         tick;

  int checks = 0, fails = 0;
  bit done = 0;
  bit chk_en = 0;
  string tag = "R1";

  tick_dist #(.NUM_PORTS(N), .PERIOD_W(32)) i_tick_dist (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_en_i(master_en), .period_i(period),
    .tick_in_valid_i(tv), .tick_in_time_i(tt), .tick_out_req_o(req),
    .tick_out_time_o(out_time), .tick_o(tick), .time_o(time_v));

  always #10 clk_i = ~clk_i;

  // reference model built from the requirements
  logic [31:0] m_cnt = '0;
  logic [7:0]  e_time = '0;
  logic        e_tick = 1'b0;
  logic [N-1:0] e_req = '0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = '0; e_time = '0; e_tick = 1'b0; e_req = '0;
    end else begin
      e_tick = 1'b0; e_req = '0;
      if (master_en) begin
        if (period == 0) m_cnt = '0;
        else if (m_cnt >= period - 1) begin
          m_cnt = '0; e_tick = 1'b1; e_req = '1;
          e_time = {2'b00, 6'(e_time[5:0] + 6'd1)};
        end else m_cnt = m_cnt + 1;
      end else begin
        int s;
        logic [7:0] nt;
        logic [N-1:0] one;
        m_cnt = '0;
        s = -1;
        for (int p = 0; p < N; p++) if (s < 0 && tv[p]) s = p;
        if (s >= 0) begin
          nt = tt[s*8 +: 8];
          e_tick = 1'b1;
          one = '0; one[s] = 1'b1;
          if (nt[5:0] == 6'(e_time[5:0] + 6'd1)) e_req = ~one;
          e_time = nt;
        end
      end
    end
  end

  function automatic string req_tag(bit m);
    if (tag != "") return tag;
    return m ? "R2 R3 R4 R6" : "R7 R8 R9 R10";
  endfunction

  always @(negedge clk_i) begin
    if (chk_en && !done) begin
      checks++;
      if (tick !== e_tick || time_v !== e_time || req !== e_req || out_time !== e_time) begin
        fails++;
        $display("FAIL %s: tick=%0b/%0b time=%h/%h req=%b/%b out_time=%h/%h (actual/expected)",
                 req_tag(master_en), tick, e_tick, time_v, e_time, req, e_req, out_time, e_time);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rand_ticks();
    for (int p = 0; p < N; p++) begin
      tv[p] = ($urandom % 3) == 0;
      if ($urandom % 2) tt[p*8 +: 8] = {2'($urandom), 6'(e_time[5:0] + 6'd1)};
      else              tt[p*8 +: 8] = 8'($urandom);
    end
  endtask

  task automatic one_tick(int p, logic [7:0] v);
    tv = '0; tv[p] = 1'b1; tt[p*8 +: 8] = v;
    cyc(1);
    tv = '0;
    cyc(1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(2);
    // R1: outputs during reset
    checks++;
    if (tick !== 1'b0 || time_v !== 8'h00 || req !== '0 || out_time !== 8'h00) begin
      fails++;
      $display("FAIL R1: tick=%0b time=%h req=%b expected all zero", tick, time_v, req);
    end
    rst_ni = 1'b1;
    chk_en = 1;
    cyc(3);

    tag = "R2 R4"; master_en = 1; period = 3; cyc(12);
    tag = "R3 R4"; period = 1; cyc(70);            // 63 -> 0 wrap
    tag = "R2";    period = 7; cyc(20); period = 2; cyc(9);
    tag = "R5";    period = 0;
    for (int i = 0; i < 20; i++) begin rand_ticks(); cyc(1); end
    tag = "R6";    period = 5;
    for (int i = 0; i < 30; i++) begin rand_ticks(); cyc(1); end
    tv = '0;

    master_en = 0;
    tag = "R7 R9"; one_tick(1, 8'hC5);
    tag = "R8";    one_tick(2, 8'h06); one_tick(0, 8'h47); one_tick(3, 8'h08);
    tag = "R8";    one_tick(1, 8'h3F); one_tick(2, 8'h00);   // wrap successor
    tag = "R9";    one_tick(0, 8'h10); one_tick(3, 8'h10);
    tag = "R10";
    tv = 4'b1010; tt = {8'h11, 8'h22, 8'h11, 8'h33}; cyc(1);
    tv = 4'b1100; tt = {8'h13, 8'h12, 8'h00, 8'h00}; cyc(1);
    tv = 4'b1111; tt = {8'h05, 8'h05, 8'h05, 8'h13}; cyc(1);
    tv = '0; cyc(2);
    tag = "R11";  one_tick(1, 8'h28);
    master_en = 1; period = 4; cyc(14);
    master_en = 0; one_tick(0, 8'h3E);
    master_en = 1; period = 1; cyc(4);

    tag = "";
    for (int seg = 0; seg < 40; seg++) begin
      master_en = $urandom % 2;
      period = $urandom % 6;
      for (int i = 0; i < 50; i++) begin rand_ticks(); cyc(1); end
    end
    tv = '0; cyc(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule